// File: doc/BRIEF.md
# Addressed Fixed-Length Frame Receiver with CRC-8 Check and Reply Builder

This block is the slave end of a byte-oriented multidrop serial control link. A UART layer, which is outside the block, hands it received bytes with a one-cycle valid strobe. The block assembles these bytes into 16-byte frames. A frame opens with the delimiter 0x40. The next three bytes carry the destination, the source and the instruction. Eleven payload bytes follow, and the last byte is a CRC-8 check.

When a frame carries this node's address, a good check byte and a known instruction, the block presents the instruction, the sender and the payload to the local controller. It then waits for the controller to supply the answer. A check-byte mismatch produces no answer and bumps a saturating error counter. Frames addressed elsewhere and frames with unknown instructions are dropped without a trace. A frame that stalls partway is thrown away after an inactivity timeout.

The reply goes out byte by byte through a ready/valid handshake to a serializer. It carries the addresses swapped, the original instruction, the controller's eleven bytes and a freshly computed check byte. The transceiver transmit enable is high only while this reply is being sent.

Top module: `frame_link_slave`

## Requirements
- R1: A frame with delimiter 0x40 at byte 0, destination (byte 1) equal to `node_addr`, instruction (byte 3) in 0..7 and a correct check byte raises `cmd_valid` for exactly one cycle, in the cycle after byte 15 is strobed. In that cycle `cmd_code` holds byte 3, `cmd_src` holds byte 2, and `cmd_data` bits [8k+7:8k] hold byte 4+k.
- R2: While the block is hunting for a frame start, any byte other than 0x40 is ignored.
- R3: A frame whose destination differs from `node_addr` (including 0xFF) produces no command, no reply and no change of `crc_err_count`.
- R4: The check byte is CRC-8 with polynomial 0x07, initial value 0, MSB first, with no reflection and no final XOR, taken over bytes 0..14. The same rule is used for the reply's byte 15.
- R5: An addressed frame with a wrong check byte produces no command and no reply, and increments `crc_err_count` by one.
- R6: `crc_err_count` resets to 0 and saturates at 255.
- R7: An addressed frame with a correct check byte and an instruction in 8..255 produces no command and leaves `crc_err_count` unchanged.
- R8: If TIMEOUT_CYCLES consecutive cycles pass with no byte strobe in the middle of a frame, the partial frame is discarded and the block returns to hunting. Gaps shorter than that keep the frame.
- R9: A `reply_start` pulse while a command is pending sends 16 bytes in this order: 0x40, the command's source, `node_addr`, the instruction, `reply_data` bytes 0..10 (byte k at bits [8k+7:8k]), and the check byte. One byte moves per cycle in which `tx_valid` and `tx_ready` are both high.
- R10: `tx_en` is high from the cycle after an accepted `reply_start` until the 16th byte is accepted, and is low at all other times.
- R11: From `cmd_valid` until the reply ends, received bytes are ignored and cannot produce a second command.
- R12: After reset, `cmd_valid`, `tx_valid` and `tx_en` are low and `crc_err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_addr | input | 8 | Address this node answers to |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| cmd_valid | output | 1 | One-cycle pulse: accepted command |
| cmd_code | output | 3 | Instruction code of the command |
| cmd_src | output | 8 | Sender address of the command |
| cmd_data | output | 88 | Eleven payload bytes, byte k at [8k+7:8k] |
| reply_start | input | 1 | Controller starts the reply |
| reply_data | input | 88 | Eleven reply payload bytes, latched at start |
| tx_ready | input | 1 | Serializer accepts a byte |
| tx_valid | output | 1 | Reply byte available |
| tx_byte | output | 8 | Reply byte |
| tx_en | output | 1 | Transceiver transmit enable |
| crc_err_count | output | 8 | Saturating count of check-byte failures |

## Verification
The assertions assume that `node_addr` stays constant while a frame is in flight. They also assume that reset is applied before the first edge they observe. The bench drives a fixed address throughout and holds reset for several cycles at the start. It strobes bytes one cycle at a time with idle cycles between them. It pulses `reply_start` only while a command is pending and only once per command. It changes `tx_ready` only on falling edges, so every reply handshake is decided by stable inputs.

// File: rtl/flink_pkg.sv
package flink_pkg;

    localparam int FRAME_BYTES = 16;
    localparam int DATA_BYTES  = 11;
    localparam int DATA_W      = DATA_BYTES * 8;
    localparam int NUM_CODES   = 8;
    localparam logic [7:0] DELIM    = 8'h40;
    localparam logic [7:0] CRC_POLY = 8'h07;
    localparam logic [3:0] LAST_IDX = 4'(FRAME_BYTES - 1);
    localparam logic [3:0] DATA_LO  = 4'd4;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_BODY,
        RX_HOLD
    } rx_state_e;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    // header fields kept for the reply
    typedef struct packed {
        byte_t dest;
        byte_t src;
        byte_t instr;
    } frame_hdr_t;

    // one byte through a CRC-8, MSB first, no reflection
    function automatic byte_t crc8_step(byte_t crc, byte_t b);
        byte_t c;
        c = crc ^ b;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/flink_rx.sv
module flink_rx
    import flink_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 100000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          node_addr,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic                release_i,
    output logic                cmd_valid,
    output logic [2:0]          cmd_code,
    output logic [7:0]          cmd_src,
    output logic [DATA_W-1:0]   cmd_data,
    output logic                crc_fail,
    output logic                busy
);

    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYCLES - 1);

    rx_state_e   state;
    logic [3:0]  idx;
    byte_t       crc_q;
    frame_hdr_t  hdr_q;
    byte_t       data_q [DATA_BYTES];
    logic [TW-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_HUNT;
            idx       <= '0;
            crc_q     <= '0;
            hdr_q     <= '0;
            timer     <= '0;
            cmd_valid <= 1'b0;
            crc_fail  <= 1'b0;
            for (int i = 0; i < DATA_BYTES; i++) data_q[i] <= '0;
        end else begin
            cmd_valid <= 1'b0;
            crc_fail  <= 1'b0;
            case (state)
                RX_HUNT: begin
                    if (rx_valid && rx_byte == DELIM) begin
                        state <= RX_BODY;
                        idx   <= 4'd1;
                        crc_q <= crc8_step(8'h00, rx_byte);
                        timer <= '0;
                    end
                end
                RX_BODY: begin
                    if (rx_valid) begin
                        timer <= '0;
                        idx   <= idx + 4'd1;
                        if (idx != LAST_IDX) crc_q <= crc8_step(crc_q, rx_byte);
                        case (idx)
                            4'd1: hdr_q.dest  <= rx_byte;
                            4'd2: hdr_q.src   <= rx_byte;
                            4'd3: hdr_q.instr <= rx_byte;
                            default: ;
                        endcase
                        for (int i = 0; i < DATA_BYTES; i++) begin
                            if (idx == DATA_LO + 4'(i)) data_q[i] <= rx_byte;
                        end
                        if (idx == LAST_IDX) begin
                            state <= RX_HUNT;
                            if (hdr_q.dest == node_addr) begin
                                if (rx_byte != crc_q) begin
                                    crc_fail <= 1'b1;
                                end else if (hdr_q.instr < 8'(NUM_CODES)) begin
                                    cmd_valid <= 1'b1;
                                    state     <= RX_HOLD;
                                end
                            end
                        end
                    end else if (timer == TMO_LAST) begin
                        state <= RX_HUNT;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (release_i) state <= RX_HUNT;
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

    assign cmd_code = hdr_q.instr[2:0];
    assign cmd_src  = hdr_q.src;
    assign busy     = (state == RX_HOLD);

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_flat
        assign cmd_data[g*8 +: 8] = data_q[g];
    end

endmodule

// File: rtl/flink_tx.sv
module flink_tx
    import flink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        node_addr,
    input  logic [7:0]        peer_addr,
    input  logic [7:0]        instr,
    input  logic [DATA_W-1:0] reply_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_en,
    output logic              done
);

    tx_state_e  state;
    logic [3:0] idx;
    byte_t      crc_q;
    byte_t      peer_q;
    byte_t      instr_q;
    byte_t      data_q [DATA_BYTES];
    logic       take;

    assign tx_valid = (state == TX_SEND);
    assign tx_en    = (state == TX_SEND);
    assign take     = tx_valid && tx_ready;
    assign done     = take && (idx == LAST_IDX);

    always_comb begin
        tx_byte = crc_q;
        case (idx)
            4'd0: tx_byte = DELIM;
            4'd1: tx_byte = peer_q;
            4'd2: tx_byte = node_addr;
            4'd3: tx_byte = instr_q;
            default: begin
                for (int i = 0; i < DATA_BYTES; i++) begin
                    if (idx == DATA_LO + 4'(i)) tx_byte = data_q[i];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            idx     <= '0;
            crc_q   <= '0;
            peer_q  <= '0;
            instr_q <= '0;
            for (int i = 0; i < DATA_BYTES; i++) data_q[i] <= '0;
        end else if (state == TX_IDLE) begin
            if (start) begin
                state   <= TX_SEND;
                idx     <= '0;
                crc_q   <= '0;
                peer_q  <= peer_addr;
                instr_q <= instr;
                for (int i = 0; i < DATA_BYTES; i++) data_q[i] <= reply_data[i*8 +: 8];
            end
        end else if (take) begin
            idx <= idx + 4'd1;
            if (idx != LAST_IDX) crc_q <= crc8_step(crc_q, tx_byte);
            if (idx == LAST_IDX) state <= TX_IDLE;
        end
    end

endmodule

// File: rtl/frame_link_slave.sv
module frame_link_slave
    import flink_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        node_addr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [7:0]        cmd_src,
    output logic [DATA_W-1:0] cmd_data,
    input  logic              reply_start,
    input  logic [DATA_W-1:0] reply_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_en,
    output logic [7:0]        crc_err_count
);

    logic crc_fail;
    logic busy;
    logic tx_done;
    logic tx_go;

    flink_rx #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .node_addr (node_addr),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .release_i (tx_done),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_src   (cmd_src),
        .cmd_data  (cmd_data),
        .crc_fail  (crc_fail),
        .busy      (busy)
    );

    assign tx_go = reply_start && busy && !tx_en;

    flink_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .start      (tx_go),
        .node_addr  (node_addr),
        .peer_addr  (cmd_src),
        .instr      ({5'd0, cmd_code}),
        .reply_data (reply_data),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .tx_en      (tx_en),
        .done       (tx_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_err_count <= '0;
        end else if (crc_fail && crc_err_count != 8'hFF) begin
            crc_err_count <= crc_err_count + 8'd1;
        end
    end

endmodule

// File: rtl/flink_checks.sv
module flink_checks (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_byte,
    input logic       tx_en,
    input logic [7:0] crc_err_count
);

    // R1: a command is announced for a single cycle only
    a_r1_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R5: the error count only ever steps up by one
    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(crc_err_count) |-> crc_err_count == $past(crc_err_count) + 8'd1);

    // R6: once full, the error count stays full
    a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
        $past(crc_err_count) == 8'hFF |-> crc_err_count == 8'hFF);

    // R11: no new command while the reply is on the wire
    a_r11_quiet_while_tx: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> !cmd_valid);

    // R9: every reply opens with the delimiter
    a_r9_first_delim: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> tx_byte == 8'h40);

    // R10: the enable holds until a byte handshake can end the reply
    a_r10_txen_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !(tx_valid && tx_ready)) |=> tx_en);

endmodule

bind frame_link_slave flink_checks u_flink_checks (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_byte       (tx_byte),
    .tx_en         (tx_en),
    .crc_err_count (crc_err_count)
);

// File: tb/tb_frame_link_slave.sv
module tb_frame_link_slave;

    localparam int TMO    = 40;
    localparam int DW     = 88;
    localparam logic [7:0] ME   = 8'd5;
    localparam logic [7:0] BOSS = 8'd192;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    node_addr = ME;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          cmd_valid;
    logic [2:0]    cmd_code;
    logic [7:0]    cmd_src;
    logic [DW-1:0] cmd_data;
    logic          reply_start = 1'b0;
    logic [DW-1:0] reply_data = '0;
    logic          tx_ready = 1'b1;
    logic          tx_valid;
    logic [7:0]    tx_byte;
    logic          tx_en;
    logic [7:0]    crc_err_count;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    frame_link_slave #(.TIMEOUT_CYCLES(TMO)) dut (
        .clk(clk), .rst(rst), .node_addr(node_addr),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_src(cmd_src), .cmd_data(cmd_data),
        .reply_start(reply_start), .reply_data(reply_data), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_en(tx_en), .crc_err_count(crc_err_count)
    );

    logic [7:0]    fr [16];
    logic [7:0]    got [16];
    int            got_n = 0;
    int            cmd_seen = 0;
    int            txen_cycles = 0;
    logic [2:0]    last_code;
    logic [7:0]    last_src;
    logic [DW-1:0] last_data;

    always @(negedge clk) begin
        if (cmd_valid) begin
            cmd_seen  <= cmd_seen + 1;
            last_code <= cmd_code;
            last_src  <= cmd_src;
            last_data <= cmd_data;
        end
        if (tx_en) txen_cycles <= txen_cycles + 1;
    end

    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            if (got_n < 16) got[got_n] <= tx_byte;
            got_n <= got_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[7] ^ fr[k][b];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    task automatic build(input logic [7:0] dst, input logic [7:0] src,
                         input logic [7:0] code, input int seed);
        fr[0] = 8'h40; fr[1] = dst; fr[2] = src; fr[3] = code;
        for (int k = 4; k < 15; k++) fr[k] = 8'((k * 17 + seed * 5) & 8'hFF);
        fr[15] = ref_crc(15);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_range(input int lo, input int hi);
        for (int k = lo; k <= hi; k++) send_byte(fr[k]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] frame_data();
        logic [DW-1:0] d;
        for (int k = 0; k < 11; k++) d[k*8 +: 8] = fr[4+k];
        return d;
    endfunction

    task automatic expect_cmd(input int base, input string req);
        check(cmd_seen == base + 1, req, cmd_seen - base, 1);
        check(last_code == fr[3][2:0] && last_src == fr[2] && last_data == frame_data(),
              req, int'(last_src), int'(fr[2]));
    endtask

    // answer a pending command; stall inserts ready-low cycles
    task automatic do_reply(input int seed, input int stall);
        logic [7:0] exp [16];
        logic [DW-1:0] rd;
        for (int k = 0; k < 11; k++) rd[k*8 +: 8] = 8'((k * 29 + seed) & 8'hFF);
        exp[0] = 8'h40; exp[1] = last_src; exp[2] = ME; exp[3] = {5'd0, last_code};
        for (int k = 0; k < 11; k++) exp[4+k] = rd[k*8 +: 8];
        for (int k = 0; k < 15; k++) fr[k] = exp[k];
        exp[15] = ref_crc(15);
        @(negedge clk);
        got_n = 0; txen_cycles = 0;
        reply_data = rd; reply_start = 1'b1;
        @(negedge clk); reply_start = 1'b0;
        if (stall > 0) begin
            tx_ready = 1'b0;
            idle(stall);
            tx_ready = 1'b1;
        end
        idle(20);
        check(got_n == 16, "R9", got_n, 16);
        for (int k = 0; k < 15; k++)
            check(got[k] == exp[k], "R9", int'(got[k]), int'(exp[k]));
        check(got[15] == exp[15], "R4", int'(got[15]), int'(exp[15]));
        check(txen_cycles == 16 + stall, "R10", txen_cycles, 16 + stall);
    endtask

    task automatic t_reset();
        check(!cmd_valid && !tx_valid && !tx_en, "R12", int'(tx_en), 0);
        check(crc_err_count == 0, "R12", int'(crc_err_count), 0);
    endtask

    task automatic t_command_and_reply();
        int base = cmd_seen;
        build(ME, BOSS, 8'd2, 1);
        send_range(0, 15);
        idle(2);
        expect_cmd(base, "R1");
        check(crc_err_count == 0, "R1", int'(crc_err_count), 0);
        // R11: a full frame while pending must be ignored
        build(ME, 8'd7, 8'd3, 2);
        send_range(0, 15);
        idle(2);
        check(cmd_seen == base + 1, "R11", cmd_seen - base, 1);
        check(!tx_en, "R10", int'(tx_en), 0);
        do_reply(3, 0);
        base = cmd_seen;
        build(ME, 8'd12, 8'd7, 4);
        send_range(0, 15);
        idle(2);
        expect_cmd(base, "R1");
        do_reply(9, 3);
    endtask

    task automatic t_hunt();
        int base = cmd_seen;
        send_byte(8'h00); send_byte(8'h41); send_byte(8'hFF); send_byte(8'hC0);
        build(ME, BOSS, 8'd5, 6);
        send_range(0, 15);
        idle(2);
        expect_cmd(base, "R2");
        do_reply(1, 0);
    endtask

    task automatic t_other_addr();
        int base = cmd_seen;
        int cnt = crc_err_count;
        txen_cycles = 0;
        build(8'd6, BOSS, 8'd1, 7);
        send_range(0, 15);
        build(8'hFF, BOSS, 8'd1, 8);
        send_range(0, 15);
        build(8'd6, BOSS, 8'd1, 9);
        fr[15] = fr[15] ^ 8'h01;
        send_range(0, 15);
        idle(20);
        check(cmd_seen == base, "R3", cmd_seen - base, 0);
        check(crc_err_count == 8'(cnt), "R3", int'(crc_err_count), cnt);
        check(txen_cycles == 0, "R3", txen_cycles, 0);
    endtask

    task automatic t_bad_crc();
        int base = cmd_seen;
        int cnt = crc_err_count;
        txen_cycles = 0;
        build(ME, BOSS, 8'd0, 10);
        fr[15] = fr[15] ^ 8'h80;
        send_range(0, 15);
        idle(20);
        check(cmd_seen == base, "R5", cmd_seen - base, 0);
        check(crc_err_count == 8'(cnt + 1), "R5", int'(crc_err_count), cnt + 1);
        check(txen_cycles == 0, "R5", txen_cycles, 0);
    endtask

    task automatic t_bad_code();
        int base = cmd_seen;
        int cnt = crc_err_count;
        build(ME, BOSS, 8'd9, 11);
        send_range(0, 15);
        build(ME, BOSS, 8'hFF, 12);
        send_range(0, 15);
        idle(4);
        check(cmd_seen == base, "R7", cmd_seen - base, 0);
        check(crc_err_count == 8'(cnt), "R7", int'(crc_err_count), cnt);
    endtask

    task automatic t_timeout();
        int base = cmd_seen;
        build(ME, 8'd33, 8'd4, 13);
        send_range(0, 6);
        idle(TMO + 20);
        build(ME, 8'd21, 8'd6, 14);
        send_range(0, 15);
        idle(2);
        expect_cmd(base, "R8");
        do_reply(2, 0);
        base = cmd_seen;
        build(ME, 8'd22, 8'd3, 15);
        send_range(0, 6);
        idle(TMO / 4);
        send_range(7, 15);
        idle(2);
        expect_cmd(base, "R8");
        do_reply(4, 0);
    endtask

    task automatic t_saturate();
        build(ME, BOSS, 8'd1, 16);
        fr[15] = fr[15] ^ 8'h3C;
        for (int n = 0; n < 260; n++) send_range(0, 15);
        idle(4);
        check(crc_err_count == 8'hFF, "R6", int'(crc_err_count), 255);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_command_and_reply();
        t_hunt();
        t_other_addr();
        t_bad_crc();
        t_bad_code();
        t_timeout();
        t_saturate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule